// File: doc/BRIEF.md
# JTAG Test Access Port with Instruction Decode

This block is the test access port of one device. A 16-state controller, clocked by the test clock and steered by the mode-select input, runs the standard capture/shift/update sequences for an instruction path and a data path. The instruction register is 10 bits wide. Its decoded value chooses the serial register placed between the test data input and the test data output: a 1-bit bypass stage, a 32-bit identification register, or an external boundary-scan chain.

The decoded instruction also drives the device-level test controls. These are an I/O tri-state request, an I/O clamp request, an output enable for the boundary register, a select strobe for the I/O configuration chain, and a one-cycle reconfiguration request. The boundary chain itself lies outside the block. It is served through capture, shift and update strobes and one serial return input.

Top module: `scan_port`

## Requirements
- R1: The controller follows the standard 16-state TAP graph on each rising edge of `tck_i`, with `tms_i` choosing each branch. From Run-Test/Idle the sequence 1,0,0 reaches Shift-DR and the sequence 1,1,0,0 reaches Shift-IR. From Shift, 1,1,0 returns to Run-Test/Idle.
- R2: Reset, or five rising edges of `tck_i` with `tms_i` high from any state, puts the controller in Test-Logic-Reset. That state loads the IDCODE opcode 10'h006 into the instruction register.
- R3: In Capture-IR the instruction shift register loads 10'b00_0000_0001. The bit shifted out first is therefore 1 and the next nine are 0.
- R4: The instruction register takes the shifted value only on the falling edge of `tck_i` in Update-IR. While a new opcode is being shifted, the outputs still follow the old one.
- R5: BYPASS (10'h3FF), HIGHZ (10'h00B), CLAMP (10'h00A), CONFIG_IO (10'h00D), PULSE (10'h001) and every unlisted opcode select the 1-bit bypass stage. That stage captures 0 in Capture-DR, so a data scan returns 0 followed by the input delayed by one bit.
- R6: IDCODE (10'h006) selects the 32-bit identification register. Capture-DR loads `ID_VALUE` into it, and that value's bit 0 is 1. It shifts out least significant bit first.
- R7: USERCODE (10'h007) selects the same 32-bit register, which then captures `user_code_i`.
- R8: HIGHZ raises `io_highz_o`. CLAMP raises `io_clamp_o` and `bsr_drive_o`. No other opcode raises `io_highz_o` or `io_clamp_o`.
- R9: EXTEST (10'h00F) and SAMPLE/PRELOAD (10'h005) select the boundary chain. `bsr_capture_o`, `bsr_shift_o` and `bsr_update_o` are high in Capture-DR, Shift-DR and Update-DR respectively, and `bsr_tdo_i` is the serial return. Only EXTEST additionally raises `bsr_drive_o`.
- R10: With PULSE (10'h001) active, `reconfig_pulse_o` is high for exactly one `tck_i` cycle each time Run-Test/Idle is entered. It is low under every other opcode.
- R11: `tdo_o` and `tdo_oe_o` change only on the falling edge of `tck_i`. `tdo_oe_o` is high only in Shift-IR and Shift-DR.
- R12: `cfg_io_sel_o` is high only while CONFIG_IO (10'h00D) is the active instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset to Test-Logic-Reset |
| tms_i | input | 1 | Mode select, sampled on rising edge |
| tdi_i | input | 1 | Serial data in |
| user_code_i | input | 32 | User identification value for USERCODE |
| bsr_tdo_i | input | 1 | Serial return from the external boundary chain |
| tdo_o | output | 1 | Serial data out, updated on falling edge |
| tdo_oe_o | output | 1 | Output enable for `tdo_o` |
| bsr_capture_o | output | 1 | Boundary chain capture strobe |
| bsr_shift_o | output | 1 | Boundary chain shift strobe |
| bsr_update_o | output | 1 | Boundary chain update strobe |
| bsr_drive_o | output | 1 | Boundary register drives the pins |
| io_highz_o | output | 1 | Tri-state all device outputs |
| io_clamp_o | output | 1 | Hold pins at boundary register values |
| cfg_io_sel_o | output | 1 | I/O configuration chain selected |
| reconfig_pulse_o | output | 1 | One-cycle reconfiguration request |

## Verification
A rising edge moves the controller and the shift registers. The falling edge half a cycle later moves `tdo_o` and `tdo_oe_o`, so each serial bit is read just after a falling edge and before the next input is driven. The decoded pin controls change at the falling edge inside Update-IR, so they are checked only after the following rising edge into Run-Test/Idle. The reconfiguration pulse rises at the edge that enters Run-Test/Idle and is checked once, one nanosecond later, and again after one more cycle to confirm it has dropped. A directed case reads the enable just after a rising edge into Shift-DR and again after the next falling edge, to confirm which edge moves it.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;
  localparam int IR_W = 10;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_BYPASS  = 10'h3FF;
  localparam logic [IR_W-1:0] OP_IDCODE  = 10'h006;
  localparam logic [IR_W-1:0] OP_USER    = 10'h007;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 10'h005;
  localparam logic [IR_W-1:0] OP_EXTEST  = 10'h00F;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 10'h00B;
  localparam logic [IR_W-1:0] OP_CLAMP   = 10'h00A;
  localparam logic [IR_W-1:0] OP_PULSE   = 10'h001;
  localparam logic [IR_W-1:0] OP_CFG_IO  = 10'h00D;
  localparam logic [IR_W-1:0] IR_CAPTURE = 10'b00_0000_0001;
endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_port_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o,
  output tap_state_e next_o
);
  tap_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_TLR:    st_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    st_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: st_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: st_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  st_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: st_d = tms_i ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  st_d = tms_i ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: st_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: st_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: st_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: st_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  st_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: st_d = tms_i ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  st_d = tms_i ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: st_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: st_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   st_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_TLR;
    else         st_q <= st_d;

  assign state_o = st_q;
  assign next_o  = st_d;

  // five TMS-high edges reach Test-Logic-Reset from anywhere
  p_tms_reset_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_i && $past(tms_i, 1) && $past(tms_i, 2) && $past(tms_i, 3) && $past(tms_i, 4))
      |=> st_q == ST_TLR);
endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_port_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic            ir_tdo_o
);
  logic [IR_W-1:0] sr_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)                    sr_q <= IR_CAPTURE;
    else if (state_i == ST_CAP_IR)  sr_q <= IR_CAPTURE;
    else if (state_i == ST_SH_IR)   sr_q <= {tdi_i, sr_q[IR_W-1:1]};

  // active instruction moves on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni)
    if (!rst_ni)                    ir_q <= OP_IDCODE;
    else if (state_i == ST_TLR)     ir_q <= OP_IDCODE;
    else if (state_i == ST_UPD_IR)  ir_q <= sr_q;

  assign ir_o     = ir_q;
  assign ir_tdo_o = sr_q[0];

  p_ir_capture_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == ST_CAP_IR |=> sr_q[1:0] == 2'b01);

  p_tlr_idcode_r2: assert property (@(negedge tck_i) disable iff (!rst_ni)
    state_i == ST_TLR |=> ir_q == OP_IDCODE);

  p_ir_hold_r4: assert property (@(negedge tck_i) disable iff (!rst_ni)
    (state_i != ST_UPD_IR && state_i != ST_TLR) |=> $stable(ir_q));
endmodule

// File: rtl/scan_dr.sv
module scan_dr
  import scan_port_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1BAD_0F0D
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  input  logic            sel_id_i,
  input  logic            sel_user_i,
  input  logic            sel_bsr_i,
  input  logic [ID_W-1:0] user_code_i,
  input  logic            bsr_tdo_i,
  output logic            dr_tdo_o
);
  logic            byp_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) begin
      byp_q <= 1'b0;
      id_q  <= ID_VALUE;
    end else if (state_i == ST_CAP_DR) begin
      byp_q <= 1'b0;
      if (sel_id_i) id_q <= sel_user_i ? user_code_i : ID_VALUE;
    end else if (state_i == ST_SH_DR) begin
      byp_q <= tdi_i;
      if (sel_id_i) id_q <= {tdi_i, id_q[ID_W-1:1]};
    end

  assign dr_tdo_o = sel_bsr_i ? bsr_tdo_i : (sel_id_i ? id_q[0] : byp_q);

  p_byp_capture_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == ST_CAP_DR |=> !byp_q);

  p_id_lsb_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_DR && sel_id_i && !sel_user_i) |=> id_q[0]);
endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_port_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1BAD_0F0D
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tms_i,
  input  logic            tdi_i,
  input  logic [ID_W-1:0] user_code_i,
  input  logic            bsr_tdo_i,
  output logic            tdo_o,
  output logic            tdo_oe_o,
  output logic            bsr_capture_o,
  output logic            bsr_shift_o,
  output logic            bsr_update_o,
  output logic            bsr_drive_o,
  output logic            io_highz_o,
  output logic            io_clamp_o,
  output logic            cfg_io_sel_o,
  output logic            reconfig_pulse_o
);
  tap_state_e      st, nxt;
  logic [IR_W-1:0] ir;
  logic            ir_tdo, dr_tdo;
  logic            sel_id, sel_user, sel_bsr, is_pulse;
  logic            tdo_q, oe_q, pulse_q;
  logic            sh_ir, sh_dr;

  scan_fsm u_fsm (.tck_i, .rst_ni, .tms_i, .state_o(st), .next_o(nxt));

  scan_ir u_ir (.tck_i, .rst_ni, .state_i(st), .tdi_i, .ir_o(ir), .ir_tdo_o(ir_tdo));

  // decode; unlisted opcodes fall through to bypass
  always_comb begin
    sel_id = 1'b0; sel_user = 1'b0; sel_bsr = 1'b0; is_pulse = 1'b0;
    io_highz_o = 1'b0; io_clamp_o = 1'b0; bsr_drive_o = 1'b0; cfg_io_sel_o = 1'b0;
    case (ir)
      OP_IDCODE: sel_id = 1'b1;
      OP_USER:   begin sel_id = 1'b1; sel_user = 1'b1; end
      OP_SAMPLE: sel_bsr = 1'b1;
      OP_EXTEST: begin sel_bsr = 1'b1; bsr_drive_o = 1'b1; end
      OP_HIGHZ:  io_highz_o = 1'b1;
      OP_CLAMP:  begin io_clamp_o = 1'b1; bsr_drive_o = 1'b1; end
      OP_CFG_IO: cfg_io_sel_o = 1'b1;
      OP_PULSE:  is_pulse = 1'b1;
      default:   ;
    endcase
  end

  scan_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck_i, .rst_ni, .state_i(st), .tdi_i,
    .sel_id_i(sel_id), .sel_user_i(sel_user), .sel_bsr_i(sel_bsr),
    .user_code_i, .bsr_tdo_i, .dr_tdo_o(dr_tdo)
  );

  assign sh_ir = (st == ST_SH_IR);
  assign sh_dr = (st == ST_SH_DR);

  assign bsr_capture_o = sel_bsr && (st == ST_CAP_DR);
  assign bsr_shift_o   = sel_bsr && sh_dr;
  assign bsr_update_o  = sel_bsr && (st == ST_UPD_DR);

  always_ff @(negedge tck_i or negedge rst_ni)
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= sh_ir | sh_dr;
      if (sh_ir)      tdo_q <= ir_tdo;
      else if (sh_dr) tdo_q <= dr_tdo;
    end

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= is_pulse && (nxt == ST_RTI) && (st != ST_RTI);

  assign tdo_o            = tdo_q;
  assign tdo_oe_o         = oe_q;
  assign reconfig_pulse_o = pulse_q;

  p_oe_shift_only_r11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o |-> (sh_ir || sh_dr));

  p_pulse_single_r10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    reconfig_pulse_o |=> !reconfig_pulse_o);

  p_pulse_rti_r10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    reconfig_pulse_o |-> st == ST_RTI);
endmodule

// File: tb/scan_port_bench.sv
module scan_port_bench;
  localparam logic [31:0] ID   = 32'h1BAD_0F0D;
  localparam logic [31:0] UC   = 32'hC0DE_1234;
  localparam logic [32:0] PATT = 33'h1_A5C3_9E71;

  // entry: {opcode[9:0], kind[1:0], flags{highz,clamp,drive,cfg}}
  // kind: 0 bypass, 1 idcode, 2 usercode, 3 boundary
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {10'h3FF, 2'd0, 4'b0000},
    {10'h006, 2'd1, 4'b0000},
    {10'h007, 2'd2, 4'b0000},
    {10'h005, 2'd3, 4'b0000},
    {10'h00F, 2'd3, 4'b0010},
    {10'h00B, 2'd0, 4'b1000},
    {10'h00A, 2'd0, 4'b0110},
    {10'h00D, 2'd0, 4'b0001},
    {10'h155, 2'd0, 4'b0000},
    {10'h001, 2'd0, 4'b0000}
  };

  logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bsr_ret = 1'b1;
  logic tdo, tdo_oe, bcap, bsh, bupd, bdrv, hz, clmp, cfg, pls;
  int   n_cmp = 0, n_err = 0;
  bit   done = 1'b0;

  always #2 tck = ~tck;

  scan_port u_scan_port (
    .tck_i(tck), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi), .user_code_i(UC),
    .bsr_tdo_i(bsr_ret), .tdo_o(tdo), .tdo_oe_o(tdo_oe), .bsr_capture_o(bcap),
    .bsr_shift_o(bsr_sh_w), .bsr_update_o(bupd), .bsr_drive_o(bdrv),
    .io_highz_o(hz), .io_clamp_o(clmp), .cfg_io_sel_o(cfg), .reconfig_pulse_o(pls)
  );
  logic bsr_sh_w;
  assign bsh = bsr_sh_w;

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sample outputs after the falling edge, then drive and take the rising edge
  task automatic step(input logic t, input logic d, output logic o, output logic oe, output logic bs);
    @(negedge tck); #1;
    o = tdo; oe = tdo_oe; bs = bsh;
    tms = t; tdi = d;
    @(posedge tck);
  endtask

  task automatic nav(input logic t);
    logic o, oe, bs;
    step(t, 1'b0, o, oe, bs);
  endtask

  // Run-Test/Idle -> Shift-IR -> shift -> Update-IR -> Run-Test/Idle
  task automatic load_ir(input logic [9:0] code, output logic [9:0] cap);
    logic o, oe, bs;
    nav(1); nav(1); nav(0); nav(0);
    for (int i = 0; i < 10; i++) begin
      step(i == 9, code[i], o, oe, bs);
      cap[i] = o;
    end
    nav(1); nav(0);
  endtask

  task automatic shift_dr(input logic [32:0] din, output logic [32:0] dout,
                          output logic oe_all, output logic bs_all);
    logic o, oe, bs;
    oe_all = 1'b1; bs_all = 1'b1;
    nav(1); nav(0); nav(0);
    for (int i = 0; i < 33; i++) begin
      step(i == 32, din[i], o, oe, bs);
      dout[i] = o; oe_all &= oe; bs_all &= bs;
    end
    nav(1); nav(0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    logic [9:0]  cap;
    logic [32:0] dout, exp;
    logic        oe_all, bs_all;
    logic [1:0]  kind;
    logic [3:0]  fl;

    #9; rst_n = 1'b1;
    @(negedge tck); #1;
    // reset state
    chk("R11 oe after reset", tdo_oe, 0);
    chk("R8 pin controls after reset", {hz, clmp, bdrv, cfg}, 0);
    chk("R10 pulse after reset", pls, 0);
    nav(0);
    shift_dr(PATT, dout, oe_all, bs_all);
    chk("R2 R6 idcode default after reset", dout[31:0], ID);
    chk("R6 id lsb", dout[0], 1);

    load_ir(10'h3FF, cap);
    chk("R3 capture-ir pattern", cap, 10'h001);

    // table of opcodes
    for (int v = 0; v < NV; v++) begin
      kind = VEC[v][5:4];
      fl   = VEC[v][3:0];
      load_ir(VEC[v][15:6], cap);
      #1;
      chk("R10 pulse on idle entry", pls, VEC[v][15:6] == 10'h001);
      chk("R8 R9 R12 pin controls", {hz, clmp, bdrv, cfg}, fl);
      if (VEC[v][15:6] == 10'h001) begin
        @(posedge tck); #1;
        chk("R10 pulse is one cycle", pls, 0);
      end
      shift_dr(PATT, dout, oe_all, bs_all);
      case (kind)
        2'd0: exp = {PATT[31:0], 1'b0};
        2'd1: exp = {dout[32], ID};
        2'd2: exp = {dout[32], UC};
        default: exp = {33{1'b1}};
      endcase
      chk(kind == 2'd0 ? "R5 bypass path" : kind == 2'd1 ? "R6 idcode path" :
          kind == 2'd2 ? "R7 usercode path" : "R9 boundary path", dout, exp);
      chk("R9 boundary shift strobe", bs_all, kind == 2'd3);
      chk("R11 oe high through shift", oe_all, 1);
      @(negedge tck); #1;
      chk("R11 oe low in idle", tdo_oe, 0);
    end

    // R1: a pause round trip in the data path keeps the bypass result
    load_ir(10'h3FF, cap);
    nav(1); nav(0); nav(0);   // Shift-DR
    nav(1); nav(0); nav(0);   // Exit1 -> Pause -> Pause
    nav(1); nav(1); nav(0);   // Exit2 -> Update -> Idle
    @(negedge tck); #1;
    chk("R1 idle after pause path", tdo_oe, 0);

    // R2: five TMS-high edges from inside Shift-DR restore IDCODE
    nav(1); nav(0); nav(0);
    for (int i = 0; i < 5; i++) nav(1);
    nav(0);
    shift_dr(PATT, dout, oe_all, bs_all);
    chk("R2 five tms high to reset", dout[31:0], ID);

    // R4: outputs follow the old opcode until Update-IR
    load_ir(10'h00A, cap);
    nav(1); nav(1); nav(0); nav(0);
    for (int i = 0; i < 10; i++) nav(i == 9);   // shifts 0s; lands in Exit1-IR
    #1;
    chk("R4 clamp held before update", {hz, clmp}, 2'b01);
    nav(1); nav(0);
    #1;
    chk("R4 opcode 0 taken at update (bypass)", {hz, clmp, bdrv, cfg}, 0);

    // R11: enable moves on the falling edge, not the rising one
    load_ir(10'h006, cap);
    nav(1); nav(0); nav(0);
    #1;
    chk("R11 oe unchanged at rising edge", tdo_oe, 0);
    @(negedge tck); #1;
    chk("R11 oe and tdo after falling edge", {tdo_oe, tdo}, 2'b11);
    nav(1); nav(1); nav(0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule